// File: doc/BRIEF.md
# Three-Level Transfer Address Sequencer

This block turns one transfer descriptor into a series of per-array commands for a data mover. The transfer has three nested levels: an array of bytes, a frame made of arrays, and a block made of frames. The descriptor gives the array length, how many arrays are in a frame, how many frames are in a block, and a reload value for the array count. It also gives a signed array stride and a signed frame stride for each of the source and the destination, plus an option word. Each synchronisation event releases either a single array or all remaining arrays of the current frame, depending on the sync-dimension option.

Each command carries a source address, a destination address, the byte length and the addressing-mode flags. It leaves the block over a valid/ready handshake. When the final array of the final frame has been accepted, a one-cycle done pulse fires, and the walked frame-start addresses are shown on the final-address outputs. Either side can instead be held at a constant address, for a peripheral FIFO. A static descriptor returns to its loaded state when it completes, so it can run again.

Top module: `xfer3d_walker`

## Requirements
- R1: After reset, cmd_valid, done and missed are 0, and fin_src and fin_dst are 0.
- R2: A load is taken only when no burst is in progress, the array length, array count and frame count are all nonzero, option bits 7:4 are zero, and in one-array mode the reload value is nonzero. A load that is not taken leaves the block unchanged.
- R3: When option bit 2 is 0, each event releases exactly one command. cmd_valid is low again in the cycle after that command's handshake.
- R4: When option bit 2 is 1, each event releases every remaining array of the current frame, one command per handshake. cmd_valid falls after the last of them.
- R5: Within a frame, each array address is the previous array address plus that side's sign-extended 16-bit array stride. The first array of a frame is the previous frame's start plus the sign-extended frame stride. All sums wrap modulo 2^AW, and zero strides repeat the same address.
- R6: When a frame ends in one-array mode, the array count restarts from the reload value. In whole-frame mode it restarts from the loaded array count.
- R7: Option bit 0 (source) and bit 1 (destination) set to 1 hold that side's address at its loaded value for the whole block. cmd_src_fix and cmd_dst_fix show these bits.
- R8: cmd_fwid shows option bits 10:8 when either side is fixed and the code is 5 or lower. Otherwise it is 0. The codes 0..5 mean 8 to 256 bits.
- R9: done is high for exactly the one cycle after the handshake of the last array of the last frame. After a non-static block, fin_src and fin_dst hold the frame start that follows the last frame.
- R10: When option bit 3 is set, completion restores the loaded addresses and counts and leaves the block armed. The next event then starts again at the loaded addresses.
- R11: An event that arrives with no block armed, with a burst in progress, or in the same cycle as a taken load starts nothing and sets the sticky missed flag. Only a taken load clears missed.
- R12: cmd_len equals the loaded array length. All command fields stay stable while cmd_valid is high and cmd_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_opt | input | 11 | Option word: fix bits 1:0, sync 2, static 3, reserved 7:4, width 10:8 |
| ld_src | input | AW | Source start address |
| ld_dst | input | AW | Destination start address |
| ld_alen | input | CW | Bytes per array |
| ld_acnt | input | CW | Arrays per frame |
| ld_fcnt | input | CW | Frames per block |
| ld_arld | input | CW | Array count reload value |
| ld_src_astr | input | SW | Source array stride (signed) |
| ld_src_fstr | input | SW | Source frame stride (signed) |
| ld_dst_astr | input | SW | Destination array stride (signed) |
| ld_dst_fstr | input | SW | Destination frame stride (signed) |
| evt | input | 1 | Synchronisation event |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by the mover |
| cmd_src | output | AW | Array source address |
| cmd_dst | output | AW | Array destination address |
| cmd_len | output | CW | Array length in bytes |
| cmd_src_fix | output | 1 | Source uses constant addressing |
| cmd_dst_fix | output | 1 | Destination uses constant addressing |
| cmd_fwid | output | 3 | FIFO width code |
| done | output | 1 | Block completion pulse |
| fin_src | output | AW | Current or final source frame start |
| fin_dst | output | AW | Current or final destination frame start |
| missed | output | 1 | Sticky ignored-event flag |

## Verification
The walk is tried with descriptors of several shapes. One-array mode with a reload value that differs from the first frame's count shows whether the reload applies only after the first frame. Whole-frame mode shows whether one event drains a frame. Negative strides that wrap below zero, and a sum that wraps past the top of the address space, show whether strides are sign-extended. Zero strides show the repeated-register case. Fixed-address sides with in-range, reserved and maximum width codes separate the mode flags from the width gating. A static descriptor separates restore-on-completion from stop-on-completion. Stalled handshakes, events after completion and during a burst, and loads that should be refused exercise the hold, missed-event and rejection paths.

// File: rtl/xfer3d_pkg.sv
package xfer3d_pkg;
  localparam int OPT_W          = 11;
  localparam int OPT_SRC_FIX    = 0;
  localparam int OPT_DST_FIX    = 1;
  localparam int OPT_SYNC_FRAME = 2;
  localparam int OPT_STATIC     = 3;
  localparam int OPT_RSV_LO     = 4;
  localparam int OPT_RSV_HI     = 7;
  localparam int OPT_FW_LO      = 8;
  localparam int OPT_FW_HI      = 10;
  localparam logic [2:0] FW_MAX = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } walk_state_e;
endpackage

// File: rtl/xfer3d_addr_walk.sv
module xfer3d_addr_walk #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_base,
  input  logic [SW-1:0] ld_astr,
  input  logic [SW-1:0] ld_fstr,
  input  logic          fixed,
  input  logic          step_en,
  input  logic          frame_end,
  input  logic          restore,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] frame_addr
);
  localparam int EXT = AW - SW;

  logic [AW-1:0] base_q, cur_q, frm_q;
  logic [AW-1:0] base_n, cur_n, frm_n;
  logic [SW-1:0] astr_q, fstr_q, astr_n, fstr_n;
  logic [AW-1:0] astr_x, fstr_x;
  logic          upd_en;

  assign astr_x = {{EXT{astr_q[SW-1]}}, astr_q};
  assign fstr_x = {{EXT{fstr_q[SW-1]}}, fstr_q};
  assign upd_en = ld_en | step_en;

  always_comb begin
    base_n = base_q;
    cur_n  = cur_q;
    frm_n  = frm_q;
    astr_n = astr_q;
    fstr_n = fstr_q;
    if (ld_en) begin
      base_n = ld_base;
      cur_n  = ld_base;
      frm_n  = ld_base;
      astr_n = ld_astr;
      fstr_n = ld_fstr;
    end else if (step_en) begin
      if (restore) begin
        cur_n = base_q;
        frm_n = base_q;
      end else if (!fixed) begin
        if (frame_end) begin
          frm_n = frm_q + fstr_x;
          cur_n = frm_q + fstr_x;
        end else begin
          cur_n = cur_q + astr_x;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
      frm_q  <= '0;
      astr_q <= '0;
      fstr_q <= '0;
    end else if (upd_en) begin
      base_q <= base_n;
      cur_q  <= cur_n;
      frm_q  <= frm_n;
      astr_q <= astr_n;
      fstr_q <= fstr_n;
    end
  end

  assign cur_addr   = cur_q;
  assign frame_addr = frm_q;
endmodule

// File: rtl/xfer3d_count.sv
module xfer3d_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_acnt,
  input  logic [CW-1:0] ld_fcnt,
  input  logic [CW-1:0] ld_arld,
  input  logic          sync_frame,
  input  logic          step_en,
  input  logic          restore,
  output logic          frame_end,
  output logic          block_end
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] acnt0_q, fcnt0_q, arld_q, aleft_q, fleft_q;
  logic [CW-1:0] acnt0_n, fcnt0_n, arld_n, aleft_n, fleft_n;
  logic          upd_en;

  assign frame_end = (aleft_q == ONE);
  assign block_end = frame_end && (fleft_q == ONE);
  assign upd_en    = ld_en | step_en;

  always_comb begin
    acnt0_n = acnt0_q;
    fcnt0_n = fcnt0_q;
    arld_n  = arld_q;
    aleft_n = aleft_q;
    fleft_n = fleft_q;
    if (ld_en) begin
      acnt0_n = ld_acnt;
      fcnt0_n = ld_fcnt;
      arld_n  = ld_arld;
      aleft_n = ld_acnt;
      fleft_n = ld_fcnt;
    end else if (step_en) begin
      if (restore) begin
        aleft_n = acnt0_q;
        fleft_n = fcnt0_q;
      end else if (frame_end) begin
        aleft_n = sync_frame ? acnt0_q : arld_q;
        fleft_n = fleft_q - ONE;
      end else begin
        aleft_n = aleft_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt0_q <= '0;
      fcnt0_q <= '0;
      arld_q  <= '0;
      aleft_q <= '0;
      fleft_q <= '0;
    end else if (upd_en) begin
      acnt0_q <= acnt0_n;
      fcnt0_q <= fcnt0_n;
      arld_q  <= arld_n;
      aleft_q <= aleft_n;
      fleft_q <= fleft_n;
    end
  end
endmodule

// File: rtl/xfer3d_walker.sv
module xfer3d_walker
  import xfer3d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [OPT_W-1:0] ld_opt,
  input  logic [AW-1:0]    ld_src,
  input  logic [AW-1:0]    ld_dst,
  input  logic [CW-1:0]    ld_alen,
  input  logic [CW-1:0]    ld_acnt,
  input  logic [CW-1:0]    ld_fcnt,
  input  logic [CW-1:0]    ld_arld,
  input  logic [SW-1:0]    ld_src_astr,
  input  logic [SW-1:0]    ld_src_fstr,
  input  logic [SW-1:0]    ld_dst_astr,
  input  logic [SW-1:0]    ld_dst_fstr,
  input  logic             evt,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [AW-1:0]    cmd_src,
  output logic [AW-1:0]    cmd_dst,
  output logic [CW-1:0]    cmd_len,
  output logic             cmd_src_fix,
  output logic             cmd_dst_fix,
  output logic [2:0]       cmd_fwid,
  output logic             done,
  output logic [AW-1:0]    fin_src,
  output logic [AW-1:0]    fin_dst,
  output logic             missed
);
  localparam int NSIDE = 2;

  walk_state_e   state_q, state_n;
  logic [1:0]    fix_q, fix_n;
  logic          sync_q, sync_n, static_q, static_n;
  logic [2:0]    fw_q, fw_n;
  logic [CW-1:0] alen_q, alen_n;
  logic          done_q, done_n, missed_q, missed_n;

  logic ld_ok, ld_acc, start, hs, last, restore, burst_end;
  logic frame_end, block_end;

  // descriptor acceptance
  assign ld_ok = (ld_alen != '0) && (ld_acnt != '0) && (ld_fcnt != '0) &&
                 (ld_opt[OPT_RSV_HI:OPT_RSV_LO] == '0) &&
                 (ld_opt[OPT_SYNC_FRAME] || (ld_arld != '0));
  assign ld_acc = ld_valid && ld_ok && (state_q != ST_RUN);

  assign cmd_valid = (state_q == ST_RUN);
  assign hs        = cmd_valid && cmd_ready;
  assign start     = (state_q == ST_ARMED) && evt && !ld_acc;
  assign last      = hs && block_end;
  assign restore   = last && static_q;
  assign burst_end = hs && (block_end || !sync_q || frame_end);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (ld_acc) state_n = ST_ARMED;
      ST_ARMED: if (ld_acc) state_n = ST_ARMED;
                else if (start) state_n = ST_RUN;
      ST_RUN:   if (burst_end)
                  state_n = (block_end && !static_q) ? ST_IDLE : ST_ARMED;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    fix_n    = fix_q;
    sync_n   = sync_q;
    static_n = static_q;
    fw_n     = fw_q;
    alen_n   = alen_q;
    if (ld_acc) begin
      fix_n    = {ld_opt[OPT_DST_FIX], ld_opt[OPT_SRC_FIX]};
      sync_n   = ld_opt[OPT_SYNC_FRAME];
      static_n = ld_opt[OPT_STATIC];
      fw_n     = ld_opt[OPT_FW_HI:OPT_FW_LO];
      alen_n   = ld_alen;
    end
    done_n   = last;
    missed_n = (missed_q && !ld_acc) || (evt && !start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      done_q   <= done_n;
      missed_q <= missed_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q    <= '0;
      sync_q   <= 1'b0;
      static_q <= 1'b0;
      fw_q     <= '0;
      alen_q   <= '0;
    end else if (ld_acc) begin
      fix_q    <= fix_n;
      sync_q   <= sync_n;
      static_q <= static_n;
      fw_q     <= fw_n;
      alen_q   <= alen_n;
    end
  end

  // per-side address walkers
  logic [NSIDE-1:0][AW-1:0] side_base, side_cur, side_frm;
  logic [NSIDE-1:0][SW-1:0] side_astr, side_fstr;

  assign side_base = {ld_dst, ld_src};
  assign side_astr = {ld_dst_astr, ld_src_astr};
  assign side_fstr = {ld_dst_fstr, ld_src_fstr};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    xfer3d_addr_walk #(.AW(AW), .SW(SW)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en      (ld_acc),
      .ld_base    (side_base[g]),
      .ld_astr    (side_astr[g]),
      .ld_fstr    (side_fstr[g]),
      .fixed      (fix_q[g]),
      .step_en    (hs),
      .frame_end  (frame_end),
      .restore    (restore),
      .cur_addr   (side_cur[g]),
      .frame_addr (side_frm[g])
    );
  end

  xfer3d_count #(.CW(CW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_acc),
    .ld_acnt    (ld_acnt),
    .ld_fcnt    (ld_fcnt),
    .ld_arld    (ld_arld),
    .sync_frame (sync_q),
    .step_en    (hs),
    .restore    (restore),
    .frame_end  (frame_end),
    .block_end  (block_end)
  );

  assign cmd_src     = side_cur[0];
  assign cmd_dst     = side_cur[1];
  assign cmd_len     = alen_q;
  assign cmd_src_fix = fix_q[0];
  assign cmd_dst_fix = fix_q[1];
  assign cmd_fwid    = ((fix_q != '0) && (fw_q <= FW_MAX)) ? fw_q : 3'd0;
  assign done        = done_q;
  assign fin_src     = side_frm[0];
  assign fin_dst     = side_frm[1];
  assign missed      = missed_q;
endmodule

// File: rtl/xfer3d_walker_chk.sv
module xfer3d_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [AW-1:0] cmd_src,
  input logic [AW-1:0] cmd_dst,
  input logic          cmd_src_fix,
  input logic          done,
  input logic          missed
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src) && $stable(cmd_dst))); // R12

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_valid && cmd_ready)); // R9

  AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (missed && !ld_valid) |=> missed); // R11

  AST_FIX_SRC_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_src_fix && $past(cmd_valid && cmd_ready && cmd_src_fix))
      |-> (cmd_src == $past(cmd_src))); // R7
endmodule

bind xfer3d_walker xfer3d_walker_chk #(.AW(AW)) u_chk (.*);

// File: tb/xfer3d_walker_tb.sv
`timescale 1ns/1ps
module xfer3d_walker_tb;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic [10:0] ld_opt = '0;
  logic [AW-1:0] ld_src = '0, ld_dst = '0;
  logic [CW-1:0] ld_alen = '0, ld_acnt = '0, ld_fcnt = '0, ld_arld = '0;
  logic [SW-1:0] ld_src_astr = '0, ld_src_fstr = '0, ld_dst_astr = '0, ld_dst_fstr = '0;
  logic evt = 1'b0;
  logic cmd_ready = 1'b0;
  logic cmd_valid, cmd_src_fix, cmd_dst_fix, done, missed;
  logic [AW-1:0] cmd_src, cmd_dst, fin_src, fin_dst;
  logic [CW-1:0] cmd_len;
  logic [2:0] cmd_fwid;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  xfer3d_walker #(.AW(AW), .CW(CW), .SW(SW)) u_dut (.*);

  typedef struct packed {
    logic [10:0] opt;
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] alen;
    logic [15:0] acnt;
    logic [15:0] fcnt;
    logic [15:0] arld;
    logic [15:0] sa;
    logic [15:0] sf;
    logic [15:0] da;
    logic [15:0] df;
    logic        stall;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{11'h000, 32'h0000_1000, 32'h0000_8000, 16'd4,  16'd3, 16'd2, 16'd2, 16'h0004, 16'h0100, 16'h0008, 16'hFFF0, 1'b0},
    '{11'h206, 32'h0000_0010, 32'h4000_0000, 16'd8,  16'd2, 16'd3, 16'd0, 16'hFFFC, 16'h0040, 16'h0004, 16'h0004, 1'b1},
    '{11'h304, 32'h0000_2000, 32'h0000_3000, 16'd2,  16'd3, 16'd1, 16'd1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    '{11'h008, 32'h0000_0500, 32'h0000_0600, 16'd1,  16'd2, 16'd2, 16'd1, 16'h0001, 16'h0010, 16'h0002, 16'h0020, 1'b0},
    '{11'h603, 32'h0000_00A0, 32'h0000_00B0, 16'd16, 16'd1, 16'd2, 16'd1, 16'h0004, 16'h0004, 16'h0004, 16'h0004, 1'b1},
    '{11'h004, 32'h0000_0002, 32'hFFFF_FFF0, 16'd4,  16'd2, 16'd1, 16'd0, 16'hFFFC, 16'h0000, 16'h0010, 16'h0000, 1'b0},
    '{11'h501, 32'h0000_0C00, 32'h0000_0D00, 16'd8,  16'd2, 16'd1, 16'd2, 16'h0008, 16'h0000, 16'h0008, 16'h0000, 1'b0}
  };

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t t);
    @(negedge clk);
    ld_opt = t.opt; ld_src = t.src; ld_dst = t.dst; ld_alen = t.alen;
    ld_acnt = t.acnt; ld_fcnt = t.fcnt; ld_arld = t.arld;
    ld_src_astr = t.sa; ld_src_fstr = t.sf; ld_dst_astr = t.da; ld_dst_fstr = t.df;
    ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic pulse_evt();
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic take_cmd(input logic [31:0] es, input logic [31:0] ed, input logic [15:0] el,
                          input logic [2:0] efw, input logic esf, input logic edf, input logic stall);
    int w;
    w = 0;
    while (!cmd_valid && w < 50) begin
      @(negedge clk);
      w++;
    end
    check("R3 command present", {31'd0, cmd_valid}, 32'd1);
    if (stall) begin
      @(negedge clk);
      check("R12 held valid", {31'd0, cmd_valid}, 32'd1);
    end
    check("R5 source address", cmd_src, es);
    check("R5 destination address", cmd_dst, ed);
    check("R12 length", {16'd0, cmd_len}, {16'd0, el});
    check("R8 width code", {29'd0, cmd_fwid}, {29'd0, efw});
    check("R7 fix flags", {30'd0, cmd_dst_fix, cmd_src_fix}, {30'd0, edf, esf});
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic run_vec(input vec_t t);
    logic sync, sfx, dfx, stat;
    logic [2:0] fw;
    logic [31:0] fs_s, fs_d, cs, cd;
    int n;
    sync = t.opt[2]; sfx = t.opt[0]; dfx = t.opt[1]; stat = t.opt[3];
    fw = ((sfx || dfx) && t.opt[10:8] <= 3'd5) ? t.opt[10:8] : 3'd0;
    load(t);
    check("R11 missed cleared by load", {31'd0, missed}, 32'd0);
    fs_s = t.src; fs_d = t.dst;
    for (int f = 0; f < int'(t.fcnt); f++) begin
      n = sync ? int'(t.acnt) : ((f == 0) ? int'(t.acnt) : int'(t.arld)); // R6
      cs = fs_s; cd = fs_d;
      for (int a = 0; a < n; a++) begin
        if (!sync || a == 0) pulse_evt();
        take_cmd(sfx ? t.src : cs, dfx ? t.dst : cd, t.alen, fw, sfx, dfx, t.stall);
        cs = cs + sx(t.sa);
        cd = cd + sx(t.da);
        if (!sync || a == n - 1) begin
          check(sync ? "R4 burst ends" : "R3 one per event", {31'd0, cmd_valid}, 32'd0);
          check("R9 done pulse", {31'd0, done},
                {31'd0, (f == int'(t.fcnt) - 1) && (a == n - 1)});
        end
      end
      fs_s = fs_s + sx(t.sf);
      fs_d = fs_d + sx(t.df);
    end
    @(negedge clk);
    check("R9 done single cycle", {31'd0, done}, 32'd0);
    if (stat) begin
      check("R10 source restored", fin_src, t.src);
      check("R10 destination restored", fin_dst, t.dst);
      pulse_evt();
      take_cmd(t.src, t.dst, t.alen, fw, sfx, dfx, 1'b0);
      check("R10 rerun no done", {31'd0, done}, 32'd0);
    end else begin
      check("R9 final source", fin_src, sfx ? t.src : fs_s);
      check("R9 final destination", fin_dst, dfx ? t.dst : fs_d);
      pulse_evt();
      check("R11 missed after completion", {31'd0, missed}, 32'd1);
      check("R11 no command after completion", {31'd0, cmd_valid}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    check("R1 cmd_valid reset", {31'd0, cmd_valid}, 32'd0);
    check("R1 done reset", {31'd0, done}, 32'd0);
    check("R1 missed reset", {31'd0, missed}, 32'd0);
    check("R1 fin_src reset", fin_src, 32'd0);
    check("R1 fin_dst reset", fin_dst, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero frame count is refused
    d = '{11'h000, 32'h0000_7700, 32'h0000_7800, 16'd4, 16'd1, 16'd0, 16'd1,
          16'h0004, 16'h0004, 16'h0004, 16'h0004, 1'b0};
    load(d);
    pulse_evt();
    check("R2 zero count refused", {31'd0, cmd_valid}, 32'd0);
    check("R2 zero count leaves state", fin_src, 32'd0);
    check("R11 event with nothing armed", {31'd0, missed}, 32'd1);
    // R2: reserved option bits refused
    d.fcnt = 16'd1;
    d.opt  = 11'h010;
    load(d);
    check("R2 reserved bits refused", fin_src, 32'd0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R2 and R11: load and event during a burst
    d = '{11'h004, 32'h0000_0100, 32'h0000_0200, 16'd4, 16'd2, 16'd1, 16'd0,
          16'h0004, 16'h0000, 16'h0004, 16'h0000, 1'b0};
    load(d);
    pulse_evt();
    ld_src = 32'h0000_0900;
    ld_valid = 1'b1;
    evt = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    evt = 1'b0;
    check("R11 event during burst", {31'd0, missed}, 32'd1);
    check("R2 load during burst ignored", cmd_src, 32'h0000_0100);
    take_cmd(32'h0000_0100, 32'h0000_0200, 16'd4, 3'd0, 1'b0, 1'b0, 1'b0);
    take_cmd(32'h0000_0104, 32'h0000_0204, 16'd4, 3'd0, 1'b0, 1'b0, 1'b0);
    check("R9 done after burst", {31'd0, done}, 32'd1);
    check("R2 final unaffected", fin_src, 32'h0000_0100);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule